// File: doc/BRIEF.md
# Store Queue with Read-Miss Bypass

This block sits between a write-through data cache and main memory. Every store the processor commits is placed in a small first-in, first-out queue holding an address and a data word. A single memory-side engine takes the oldest queued store and issues it to memory through a request/acknowledge handshake. Only one transaction is outstanding at a time.

When the cache takes a read miss, it raises a read request with the miss address and holds it. The block compares that address, at word granularity, against every occupied queue slot in parallel. If no slot holds the same word, the read is given the memory port ahead of the queued stores as soon as the port is free. If any slot holds the same word, the read is held back until those stores have reached memory. A full queue refuses new stores, and the processor must stall.

Top module: `wr_queue_bypass`

## Requirements
- R1: After reset the queue is empty (`empty`=1, `full`=0), no memory request is raised (`mem_req`=0) and `rd_blocked`=0.
- R2: A store presented with `st_valid`=1 while `full`=0 is accepted at that clock edge; `full` rises on the edge that accepts the fourth queued store and `empty` falls on the edge that accepts the first.
- R3: A store presented while `full`=1 is dropped: it is never written to memory and the queue contents are unchanged.
- R4: Queued stores are issued to memory strictly oldest first, with `mem_we`=1 and the address and data exactly as they were accepted.
- R5: Once `mem_req` is raised, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until a cycle in which `mem_ack`=1; that cycle completes the transaction and `mem_req` is low in the following cycle.
- R6: A read request whose word address (bits 31:2) matches no occupied slot is issued as a read (`mem_we`=0, `mem_addr` = the miss address) before any queued store, once no transaction is in flight.
- R7: A read request whose word address matches an occupied slot, even if the byte offset bits 1:0 differ, raises `rd_blocked` and is not issued until every matching store has been acknowledged; the stores in front of and including the youngest match go first, and the read then precedes any younger store.
- R8: When the memory port becomes free and both a conflict-free read and a queued store are waiting, the read is issued; `rd_done` is high exactly in the cycle whose `mem_ack` completes the read.
- R9: A store accepted in the same cycle that a queued store is acknowledged leaves the occupancy unchanged, so the queue fills after exactly as many further stores as it had free slots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Processor presents a committed store |
| st_addr | input | 32 | Store byte address |
| st_data | input | 32 | Store data word |
| rd_req | input | 1 | Read miss pending; held until `rd_done` |
| rd_addr | input | 32 | Read miss byte address |
| rd_blocked | output | 1 | Pending read conflicts with a queued store |
| rd_done | output | 1 | Read transaction acknowledged this cycle |
| mem_req | output | 1 | Memory transaction outstanding |
| mem_we | output | 1 | 1 = store, 0 = read |
| mem_addr | output | 32 | Transaction address |
| mem_wdata | output | 32 | Store data (zero for reads) |
| mem_ack | input | 1 | Memory completes the outstanding transaction |
| full | output | 1 | All slots occupied; processor must stall |
| empty | output | 1 | No slot occupied |

## Verification
Two pairs of events can coincide: a store entering while the head store is acknowledged, and a read miss competing with a queued store at the moment the port frees up. The first is provoked by raising `st_valid` in the very cycle `mem_ack` completes a store with three slots in use, and judged by showing that exactly one more store then fills the queue. The second is provoked by raising a read miss while a store is in flight with another behind it, and judged by the type and address of the next transaction; a same-word miss with a different byte offset checks that the arbitration yields to the conflicting store instead.

// File: rtl/wbuf_pkg.sv
`timescale 1ns/1ps
package wbuf_pkg;
  typedef enum logic [0:0] {
    OP_WRITE = 1'b0,
    OP_READ  = 1'b1
  } mem_op_e;
endpackage

// File: rtl/wbuf_fifo.sv
`timescale 1ns/1ps
// Store queue storage: addresses in flops for parallel compare,
// data in an array written like a small RAM.
module wbuf_fifo #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     st_valid,
  input  logic [AW-1:0]            st_addr,
  input  logic [DW-1:0]            st_data,
  input  logic                     pop,
  output logic                     full,
  output logic                     empty,
  output logic [AW-1:0]            head_addr,
  output logic [DW-1:0]            head_data,
  output logic [DEPTH-1:0][AW-1:0] ent_addr,
  output logic [DEPTH-1:0]         ent_valid
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [PW-1:0]            wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]            count_q, count_next;
  logic                     full_q, empty_q;
  logic                     wr_en;
  logic [DEPTH-1:0][AW-1:0] addr_q;
  logic [DW-1:0]            data_mem [DEPTH];

  assign wr_en      = st_valid && !full_q;
  assign count_next = count_q + CW'(wr_en) - CW'(pop);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      full_q   <= 1'b0;
      empty_q  <= 1'b1;
    end else begin
      if (wr_en) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (pop)   rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      count_q <= count_next;
      full_q  <= (count_next == CW'(DEPTH));
      empty_q <= (count_next == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else if (wr_en) addr_q[wr_ptr_q] <= st_addr;
  end

  always_ff @(posedge clk) begin
    if (wr_en) data_mem[wr_ptr_q] <= st_data;
  end

  assign head_addr = addr_q[rd_ptr_q];
  assign head_data = data_mem[rd_ptr_q];
  assign ent_addr  = addr_q;
  assign full      = full_q;
  assign empty     = empty_q;

  // A slot is occupied when its distance from the read pointer is below the count.
  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_occ
      logic [PW:0] rel;
      always_comb begin
        rel = (PW+1)'(i) + (PW+1)'(DEPTH) - {1'b0, rd_ptr_q};
        if (rel >= (PW+1)'(DEPTH)) rel = rel - (PW+1)'(DEPTH);
        ent_valid[i] = (CW'(rel) < count_q);
      end
    end
  endgenerate

  a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
    count_q <= CW'(DEPTH));
  a_r3_full_blocks: assert property (@(posedge clk) disable iff (rst)
    full_q && !pop |=> full_q && $stable(count_q));
  a_r4_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty_q);
endmodule

// File: rtl/wbuf_match.sv
`timescale 1ns/1ps
// Parallel word-address compare of the read miss against occupied slots.
module wbuf_match #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int OFFW  = 2
) (
  input  logic [AW-1:0]            rd_addr,
  input  logic [DEPTH-1:0][AW-1:0] ent_addr,
  input  logic [DEPTH-1:0]         ent_valid,
  output logic                     conflict
);
  localparam logic [AW-1:0] WORD_MASK = ~((AW'(1) << OFFW) - AW'(1));

  logic [DEPTH-1:0] hit;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      assign hit[i] = ent_valid[i] && (((ent_addr[i] ^ rd_addr) & WORD_MASK) == '0);
    end
  endgenerate

  assign conflict = |hit;
endmodule

// File: rtl/wbuf_port.sv
`timescale 1ns/1ps
// Memory-side engine: one outstanding transaction, read has priority when clean.
module wbuf_port
  import wbuf_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  input  logic          conflict,
  input  logic          empty,
  input  logic [AW-1:0] head_addr,
  input  logic [DW-1:0] head_data,
  input  logic          mem_ack,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          pop,
  output logic          rd_done
);
  logic          busy_q;
  mem_op_e       op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          issue_rd, issue_wr, done;

  always_comb begin
    issue_rd = !busy_q && rd_req && !conflict;
    issue_wr = !busy_q && !issue_rd && !empty;
    done     = busy_q && mem_ack;
  end

  assign pop     = done && (op_q == OP_WRITE);
  assign rd_done = done && (op_q == OP_READ);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      op_q   <= OP_WRITE;
      addr_q <= '0;
      data_q <= '0;
    end else if (done) begin
      busy_q <= 1'b0;
    end else if (issue_rd) begin
      busy_q <= 1'b1;
      op_q   <= OP_READ;
      addr_q <= rd_addr;
      data_q <= '0;
    end else if (issue_wr) begin
      busy_q <= 1'b1;
      op_q   <= OP_WRITE;
      addr_q <= head_addr;
      data_q <= head_data;
    end
  end

  assign mem_req   = busy_q;
  assign mem_we    = busy_q && (op_q == OP_WRITE);
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;

  a_r5_req_held: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));
  a_r5_ack_ends: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ack |=> !mem_req);
  a_r6_clean_read_issues: assert property (@(posedge clk) disable iff (rst)
    !mem_req && rd_req && !conflict |=> mem_req && !mem_we && (mem_addr == $past(rd_addr)));
  a_r7_conflict_holds_read: assert property (@(posedge clk) disable iff (rst)
    !mem_req && rd_req && conflict |=> !(mem_req && !mem_we));
  a_r8_done_is_read: assert property (@(posedge clk) disable iff (rst)
    rd_done |-> mem_req && !mem_we && mem_ack);
endmodule

// File: rtl/wr_queue_bypass.sv
`timescale 1ns/1ps
module wr_queue_bypass #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int OFFW  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_blocked,
  output logic          rd_done,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  output logic          full,
  output logic          empty
);
  logic                     pop, conflict;
  logic [AW-1:0]            head_addr;
  logic [DW-1:0]            head_data;
  logic [DEPTH-1:0][AW-1:0] ent_addr;
  logic [DEPTH-1:0]         ent_valid;

  wbuf_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .st_valid  (st_valid),
    .st_addr   (st_addr),
    .st_data   (st_data),
    .pop       (pop),
    .full      (full),
    .empty     (empty),
    .head_addr (head_addr),
    .head_data (head_data),
    .ent_addr  (ent_addr),
    .ent_valid (ent_valid)
  );

  wbuf_match #(.DEPTH(DEPTH), .AW(AW), .OFFW(OFFW)) u_match (
    .rd_addr   (rd_addr),
    .ent_addr  (ent_addr),
    .ent_valid (ent_valid),
    .conflict  (conflict)
  );

  wbuf_port #(.AW(AW), .DW(DW)) u_port (
    .clk       (clk),
    .rst       (rst),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .conflict  (conflict),
    .empty     (empty),
    .head_addr (head_addr),
    .head_data (head_data),
    .mem_ack   (mem_ack),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .pop       (pop),
    .rd_done   (rd_done)
  );

  assign rd_blocked = rd_req && conflict;

  a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
  a_r7_blocked_no_read: assert property (@(posedge clk) disable iff (rst)
    rd_blocked |-> !(mem_req && !mem_we));
endmodule

// File: tb/sim_wr_queue_bypass.sv
`timescale 1ns/1ps
module sim_wr_queue_bypass;
  logic        clk, rst;
  logic        st_valid, rd_req, mem_ack;
  logic [31:0] st_addr, st_data, rd_addr;
  logic        rd_blocked, rd_done, mem_req, mem_we, full, empty;
  logic [31:0] mem_addr, mem_wdata;

  int n_chk  = 0;
  int n_fail = 0;
  bit done_flag = 0;

  wr_queue_bypass u0 (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_blocked(rd_blocked), .rd_done(rd_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .full(full), .empty(empty)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic logic [31:0] dval(input logic [31:0] a);
    return a ^ 32'h5A5A_C3C3;
  endfunction

  task automatic push(input logic [31:0] a);
    st_valid = 1'b1; st_addr = a; st_data = dval(a);
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic wait_req(input string req);
    for (int k = 0; k < 200; k++) begin
      if (mem_req) return;
      @(negedge clk);
    end
    chk(req, "timeout waiting for mem_req", 32'd0, 32'd1);
  endtask

  // Wait for next transaction, check it, acknowledge it.
  task automatic expect_txn(input string req, input logic we, input logic [31:0] a);
    wait_req(req);
    chk(req, "mem_we", {31'd0, mem_we}, {31'd0, we});
    chk(req, "mem_addr", mem_addr, a);
    if (we) chk(req, "mem_wdata", mem_wdata, dval(a));
    mem_ack = 1'b1;
    #1;
    chk("R8", "rd_done at ack", {31'd0, rd_done}, {31'd0, !we});
    @(negedge clk);
    mem_ack = 1'b0;
    if (!we) rd_req = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "empty", {31'd0, empty}, 32'd1);
    chk("R1", "full", {31'd0, full}, 32'd0);
    chk("R1", "mem_req", {31'd0, mem_req}, 32'd0);
    chk("R1", "rd_blocked", {31'd0, rd_blocked}, 32'd0);
  endtask

  task automatic t_fill_and_drain();
    logic [31:0] a0;
    push(32'h0000_1000);
    chk("R2", "empty after first store", {31'd0, empty}, 32'd0);
    push(32'h0000_1004);
    push(32'h0000_1008);
    chk("R2", "full at three", {31'd0, full}, 32'd0);
    push(32'h0000_100C);
    chk("R2", "full at four", {31'd0, full}, 32'd1);
    push(32'h0000_9990);
    chk("R3", "full after dropped store", {31'd0, full}, 32'd1);
    wait_req("R5");
    a0 = mem_addr;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R5", "mem_req held", {31'd0, mem_req}, 32'd1);
      chk("R5", "mem_addr held", mem_addr, a0);
    end
    expect_txn("R4", 1'b1, 32'h0000_1000);
    chk("R5", "mem_req low after ack", {31'd0, mem_req}, 32'd0);
    expect_txn("R4", 1'b1, 32'h0000_1004);
    expect_txn("R4", 1'b1, 32'h0000_1008);
    expect_txn("R4", 1'b1, 32'h0000_100C);
    for (int k = 0; k < 5; k++) begin
      chk("R3", "no write of dropped store", {31'd0, mem_req}, 32'd0);
      @(negedge clk);
    end
    chk("R3", "empty after drain", {31'd0, empty}, 32'd1);
  endtask

  task automatic t_bypass();
    push(32'h0000_0100);
    push(32'h0000_0200);
    rd_req = 1'b1; rd_addr = 32'h0000_0300;
    #1;
    chk("R6", "rd_blocked clean miss", {31'd0, rd_blocked}, 32'd0);
    expect_txn("R4", 1'b1, 32'h0000_0100);
    expect_txn("R8", 1'b0, 32'h0000_0300);
    expect_txn("R6", 1'b1, 32'h0000_0200);
    chk("R6", "empty after bypass case", {31'd0, empty}, 32'd1);
  endtask

  task automatic t_conflict();
    push(32'h0000_0400);
    push(32'h0000_0500);
    push(32'h0000_0600);
    rd_req = 1'b1; rd_addr = 32'h0000_0503;
    #1;
    chk("R7", "rd_blocked on same word", {31'd0, rd_blocked}, 32'd1);
    expect_txn("R7", 1'b1, 32'h0000_0400);
    chk("R7", "still blocked", {31'd0, rd_blocked}, 32'd1);
    expect_txn("R7", 1'b1, 32'h0000_0500);
    chk("R7", "unblocked after match drained", {31'd0, rd_blocked}, 32'd0);
    expect_txn("R7", 1'b0, 32'h0000_0503);
    expect_txn("R7", 1'b1, 32'h0000_0600);
  endtask

  task automatic t_same_cycle();
    push(32'h0000_2000);
    push(32'h0000_2004);
    push(32'h0000_2008);
    wait_req("R9");
    chk("R9", "head in flight", mem_addr, 32'h0000_2000);
    mem_ack = 1'b1;
    st_valid = 1'b1; st_addr = 32'h0000_200C; st_data = dval(32'h0000_200C);
    @(negedge clk);
    mem_ack = 1'b0; st_valid = 1'b0;
    chk("R9", "not full after push+pop", {31'd0, full}, 32'd0);
    push(32'h0000_2010);
    chk("R9", "full after one more", {31'd0, full}, 32'd1);
    expect_txn("R9", 1'b1, 32'h0000_2004);
    expect_txn("R9", 1'b1, 32'h0000_2008);
    expect_txn("R9", 1'b1, 32'h0000_200C);
    expect_txn("R9", 1'b1, 32'h0000_2010);
    chk("R9", "empty at end", {31'd0, empty}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual expired expected finish");
    report();
  end

  initial begin
    rst = 1'b1; st_valid = 1'b0; rd_req = 1'b0; mem_ack = 1'b0;
    st_addr = '0; st_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fill_and_drain();
    t_bypass();
    t_conflict();
    t_same_cycle();
    repeat (3) @(negedge clk);
    report();
  end
endmodule